// File: doc/BRIEF.md
# Blackjack round control FSM

This block runs a game of blackjack between one player and an automatic dealer and keeps the player's credit balance. It takes a bet value, single-cycle advance, hit and stand pulses, one card-valid acknowledge shared by both hands, and the running totals of the two hands from external scorers. It produces single-cycle draw requests aimed at the player or the dealer side, a flag that says when the dealer's second card may be shown, the balance, a state code and a game-over flag.

A round starts in the betting state. An advance press with a non-zero bet deals four cards in the order player, dealer, player, dealer. The player then hits or stands. A bust settles the round at once. A stand hands control to the dealer, who draws until its total reaches 17. The totals are then compared and the bet is settled. Play returns to betting until the balance hits the floor (0) or the ceiling (1000). Either one locks the block in a game-over state until reset.

Top module: `bj_round_ctrl`

## Requirements
- R1: After reset the balance is 200, the state code is 0 (betting), and draw_player, draw_dealer, hole_reveal and game_over are all 0.
- R2: In the betting state an advance press while bet_in is 0 leaves the state code at 0 and requests no card. An advance press with a non-zero bet starts the deal.
- R3: The deal issues four draw requests in the order player, dealer, player, dealer. Each request waits for its card_valid before the next one is issued. After the fourth acknowledge the state code becomes 3 (player turn).
- R4: hole_reveal is 0 from bet acceptance through the whole player turn. It is 1 from the cycle after an accepted stand until the next bet is accepted.
- R5: Each hit in the player turn produces exactly one player draw request. A player total above 21 in the player turn subtracts the bet without any dealer draw request.
- R6: After a stand the dealer side is requested to draw while the dealer total is 16 or less. No further dealer card is requested once the dealer total is 17 or more.
- R7: Settlement adds the bet when the player total is higher or the dealer total is above 21. It leaves the balance unchanged on equal totals and subtracts the bet when the player total is lower. A win never lifts the balance above 1000. The balance changes at no other time.
- R8: When the balance after settlement is 0 or 1000, the state code becomes 11 and game_over becomes 1. After that, advance, hit and stand change neither the state nor the balance and request no card.
- R9: A bet larger than the balance is reduced to the balance when it is accepted, so a lost round with such a bet leaves exactly 0.
- R10: Every draw request lasts exactly one cycle, and draw_player and draw_dealer are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bet_in | input | 4 | Requested bet, 0 to 15 credits |
| advance | input | 1 | Debounced advance pulse, leaves betting |
| hit | input | 1 | Debounced hit pulse |
| stand | input | 1 | Debounced stand pulse, wins over a coincident hit |
| card_valid | input | 1 | Acknowledge that the requested card was added to its hand |
| player_total | input | 5 | Player hand total from its scorer |
| dealer_total | input | 5 | Dealer hand total from its scorer |
| draw_player | output | 1 | One-cycle request for a player card |
| draw_dealer | output | 1 | One-cycle request for a dealer card |
| hole_reveal | output | 1 | Dealer's second card may be shown |
| balance | output | 10 | Current credit balance |
| state_code | output | 4 | Current state code (0 betting, 3 player turn, 6 dealer evaluate, 11 game over) |
| game_over | output | 1 | Game has ended at the floor or the ceiling |

## Verification
Inputs are driven on the falling edge, so the next rising edge registers them and the result is sampled on the following falling edge. An advance or hit raises its draw request one cycle later. A card_valid has to arrive one cycle after the request is seen, and the next request follows one cycle after it. A stand shows hole_reveal and state code 6 one cycle later. The balance settles two cycles after the last evaluation, when the state code returns to 0 or reaches 11. The bench therefore waits for that state code before it compares the balance with its own running model. It also checks on every falling edge of the wait that no dealer card is requested after a bust.

// File: rtl/bj_pkg.sv
package bj_pkg;

  typedef enum logic [3:0] {
    ST_BET    = 4'd0,
    ST_DEAL   = 4'd1,
    ST_DEALW  = 4'd2,
    ST_PLAY   = 4'd3,
    ST_PHIT   = 4'd4,
    ST_PHITW  = 4'd5,
    ST_DLR    = 4'd6,
    ST_DHIT   = 4'd7,
    ST_DHITW  = 4'd8,
    ST_SETTLE = 4'd9,
    ST_CHECK  = 4'd10,
    ST_OVER   = 4'd11
  } bj_state_e;

  typedef enum logic [1:0] {
    OC_LOSE = 2'd0,
    OC_PUSH = 2'd1,
    OC_WIN  = 2'd2
  } bj_outcome_e;

  // Round verdict from the two totals; bust_lim is the highest legal total.
  function automatic bj_outcome_e judge(input int ptot, input int dtot, input int bust_lim);
    if (ptot > bust_lim)      return OC_LOSE;
    else if (dtot > bust_lim) return OC_WIN;
    else if (ptot > dtot)     return OC_WIN;
    else if (ptot == dtot)    return OC_PUSH;
    else                      return OC_LOSE;
  endfunction

  // Stake actually accepted: never more than the credits held.
  function automatic int clamp_bet(input int req, input int bal);
    return (req > bal) ? bal : req;
  endfunction

  // Balance after settlement, winnings saturate at the ceiling.
  function automatic int settle_bal(input int bal, input int stake,
                                    input bj_outcome_e oc, input int ceil_v);
    int r;
    case (oc)
      OC_WIN:  r = (bal + stake > ceil_v) ? ceil_v : bal + stake;
      OC_LOSE: r = bal - stake;
      default: r = bal;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bj_ledger.sv
module bj_ledger #(
  parameter int BET_W     = 4,
  parameter int BAL_W     = 10,
  parameter int START_BAL = 200,
  parameter int CEIL_BAL  = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bet_accept,
  input  logic [BET_W-1:0]    bet_in,
  input  logic                settle_fire,
  input  bj_pkg::bj_outcome_e outcome,
  output logic [BAL_W-1:0]    balance
);
  logic [BET_W-1:0] stake_q;
  logic [BAL_W-1:0] bal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stake_q <= '0;
      bal_q   <= BAL_W'(START_BAL);
    end else begin
      if (bet_accept)
        stake_q <= BET_W'(bj_pkg::clamp_bet(int'(bet_in), int'(bal_q)));
      if (settle_fire)
        bal_q <= BAL_W'(bj_pkg::settle_bal(int'(bal_q), int'(stake_q), outcome, CEIL_BAL));
    end
  end

  assign balance = bal_q;
endmodule

// File: rtl/bj_fsm.sv
module bj_fsm #(
  parameter int BET_W    = 4,
  parameter int BAL_W    = 10,
  parameter int TOT_W    = 5,
  parameter int BUST_LIM = 21,
  parameter int D_STAND  = 17,
  parameter int CEIL_BAL = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BET_W-1:0]    bet_in,
  input  logic                advance,
  input  logic                hit,
  input  logic                stand,
  input  logic                card_valid,
  input  logic [TOT_W-1:0]    player_total,
  input  logic [TOT_W-1:0]    dealer_total,
  input  logic [BAL_W-1:0]    balance,
  output bj_pkg::bj_state_e   state,
  output logic                bet_accept,
  output logic                settle_fire,
  output bj_pkg::bj_outcome_e outcome,
  output logic                draw_player,
  output logic                draw_dealer,
  output logic                hole_reveal
);
  import bj_pkg::*;

  localparam logic [TOT_W-1:0] BUST_V  = TOT_W'(BUST_LIM);
  localparam logic [TOT_W-1:0] STAND_V = TOT_W'(D_STAND);
  localparam logic [BAL_W-1:0] CEIL_V  = BAL_W'(CEIL_BAL);

  bj_state_e st_q, st_d;
  logic [1:0] deal_cnt;
  logic       reveal_q;
  logic       p_bust, d_wants, game_end;

  assign p_bust   = player_total > BUST_V;
  assign d_wants  = dealer_total < STAND_V;
  assign game_end = (balance == '0) || (balance >= CEIL_V);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_BET:    if (advance && (bet_in != '0)) st_d = ST_DEAL;
      ST_DEAL:   st_d = ST_DEALW;
      ST_DEALW:  if (card_valid) st_d = (deal_cnt == 2'd3) ? ST_PLAY : ST_DEAL;
      ST_PLAY: begin
        if (p_bust)     st_d = ST_SETTLE;
        else if (stand) st_d = ST_DLR;
        else if (hit)   st_d = ST_PHIT;
      end
      ST_PHIT:   st_d = ST_PHITW;
      ST_PHITW:  if (card_valid) st_d = ST_PLAY;
      ST_DLR:    st_d = d_wants ? ST_DHIT : ST_SETTLE;
      ST_DHIT:   st_d = ST_DHITW;
      ST_DHITW:  if (card_valid) st_d = ST_DLR;
      ST_SETTLE: st_d = ST_CHECK;
      ST_CHECK:  st_d = game_end ? ST_OVER : ST_BET;
      ST_OVER:   st_d = ST_OVER;
      default:   st_d = ST_BET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_BET;
      deal_cnt <= 2'd0;
      reveal_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_BET)
        deal_cnt <= 2'd0;
      else if (st_q == ST_DEALW && card_valid)
        deal_cnt <= deal_cnt + 2'd1;
      if (bet_accept)
        reveal_q <= 1'b0;
      else if (st_q == ST_PLAY && stand && !p_bust)
        reveal_q <= 1'b1;
    end
  end

  assign state       = st_q;
  assign bet_accept  = (st_q == ST_BET) && advance && (bet_in != '0);
  assign settle_fire = (st_q == ST_SETTLE);
  assign outcome     = judge(int'(player_total), int'(dealer_total), BUST_LIM);
  assign draw_player = ((st_q == ST_DEAL) && !deal_cnt[0]) || (st_q == ST_PHIT);
  assign draw_dealer = ((st_q == ST_DEAL) &&  deal_cnt[0]) || (st_q == ST_DHIT);
  assign hole_reveal = reveal_q;
endmodule

// File: rtl/bj_round_ctrl.sv
module bj_round_ctrl #(
  parameter int BET_W     = 4,
  parameter int BAL_W     = 10,
  parameter int TOT_W     = 5,
  parameter int START_BAL = 200,
  parameter int CEIL_BAL  = 1000,
  parameter int BUST_LIM  = 21,
  parameter int D_STAND   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BET_W-1:0] bet_in,
  input  logic             advance,
  input  logic             hit,
  input  logic             stand,
  input  logic             card_valid,
  input  logic [TOT_W-1:0] player_total,
  input  logic [TOT_W-1:0] dealer_total,
  output logic             draw_player,
  output logic             draw_dealer,
  output logic             hole_reveal,
  output logic [BAL_W-1:0] balance,
  output logic [3:0]       state_code,
  output logic             game_over
);
  import bj_pkg::*;

  bj_state_e   state;
  bj_outcome_e outcome;
  logic        bet_accept;
  logic        settle_fire;

  bj_fsm #(
    .BET_W(BET_W), .BAL_W(BAL_W), .TOT_W(TOT_W),
    .BUST_LIM(BUST_LIM), .D_STAND(D_STAND), .CEIL_BAL(CEIL_BAL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .bet_in(bet_in), .advance(advance),
    .hit(hit), .stand(stand), .card_valid(card_valid),
    .player_total(player_total), .dealer_total(dealer_total),
    .balance(balance), .state(state), .bet_accept(bet_accept),
    .settle_fire(settle_fire), .outcome(outcome),
    .draw_player(draw_player), .draw_dealer(draw_dealer),
    .hole_reveal(hole_reveal)
  );

  bj_ledger #(
    .BET_W(BET_W), .BAL_W(BAL_W), .START_BAL(START_BAL), .CEIL_BAL(CEIL_BAL)
  ) u_ledger (
    .clk(clk), .rst_n(rst_n), .bet_accept(bet_accept), .bet_in(bet_in),
    .settle_fire(settle_fire), .outcome(outcome), .balance(balance)
  );

  assign state_code = state;
  assign game_over  = (state == ST_OVER);
endmodule

// File: rtl/bj_round_ctrl_chk.sv
module bj_round_ctrl_chk #(
  parameter int BET_W    = 4,
  parameter int BAL_W    = 10,
  parameter int TOT_W    = 5,
  parameter int CEIL_BAL = 1000,
  parameter int BUST_LIM = 21,
  parameter int D_STAND  = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BET_W-1:0] bet_in,
  input logic [TOT_W-1:0] player_total,
  input logic [TOT_W-1:0] dealer_total,
  input logic             draw_player,
  input logic             draw_dealer,
  input logic             hole_reveal,
  input logic [BAL_W-1:0] balance,
  input logic [3:0]       state_code,
  input logic             game_over,
  input logic             settle_fire
);
  localparam logic [3:0] C_BET    = 4'd0;
  localparam logic [3:0] C_PLAY   = 4'd3;
  localparam logic [3:0] C_DLR    = 4'd6;
  localparam logic [3:0] C_SETTLE = 4'd9;
  localparam logic [TOT_W-1:0] BUST_V  = TOT_W'(BUST_LIM);
  localparam logic [TOT_W-1:0] STAND_V = TOT_W'(D_STAND);
  localparam logic [BAL_W-1:0] CEIL_V  = BAL_W'(CEIL_BAL);

  p_zero_bet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == C_BET && bet_in == '0) |=> (state_code == C_BET));

  p_hole_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == C_PLAY) |-> !hole_reveal);

  p_bust_settles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == C_PLAY && player_total > BUST_V) |=> (state_code == C_SETTLE));

  p_dealer_stands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == C_DLR && dealer_total >= STAND_V) |=> !draw_dealer);

  p_bal_only_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !settle_fire |=> $stable(balance));

  p_bal_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    balance <= CEIL_V);

  p_over_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    game_over |=> (game_over && $stable(balance) && !draw_player && !draw_dealer));

  p_player_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    draw_player |=> !draw_player);

  p_dealer_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    draw_dealer |=> !draw_dealer);

  p_one_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({draw_player, draw_dealer}));
endmodule

bind bj_round_ctrl bj_round_ctrl_chk #(
  .BET_W(BET_W), .BAL_W(BAL_W), .TOT_W(TOT_W),
  .CEIL_BAL(CEIL_BAL), .BUST_LIM(BUST_LIM), .D_STAND(D_STAND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bet_in(bet_in),
  .player_total(player_total), .dealer_total(dealer_total),
  .draw_player(draw_player), .draw_dealer(draw_dealer),
  .hole_reveal(hole_reveal), .balance(balance), .state_code(state_code),
  .game_over(game_over), .settle_fire(settle_fire)
);

// File: tb/bj_round_ctrl_test.sv
`timescale 1ns/1ps
module bj_round_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bet_in = '0;
  logic       advance = 1'b0, hit = 1'b0, stand = 1'b0, card_valid = 1'b0;
  logic [4:0] player_total = '0, dealer_total = '0;
  logic       draw_player, draw_dealer, hole_reveal, game_over;
  logic [9:0] balance;
  logic [3:0] state_code;

  int checks = 0;
  int errors = 0;
  int exp_bal = 200;
  int cycles = 0;

  always #10 clk = ~clk;

  bj_round_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bet_in(bet_in), .advance(advance),
    .hit(hit), .stand(stand), .card_valid(card_valid),
    .player_total(player_total), .dealer_total(dealer_total),
    .draw_player(draw_player), .draw_dealer(draw_dealer),
    .hole_reveal(hole_reveal), .balance(balance),
    .state_code(state_code), .game_over(game_over)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_bal = 200;
    @(negedge clk);
  endtask

  // Wait for a draw request, check its side and width, then acknowledge it.
  task automatic serve(input bit to_dealer, input int ptot, input int dtot, input string tag);
    int n = 0;
    while (!(draw_player || draw_dealer) && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(draw_dealer == to_dealer && (draw_player != draw_dealer), tag,
        {draw_player, draw_dealer}, to_dealer ? 1 : 2);
    @(negedge clk);
    chk(!draw_player && !draw_dealer, "R10 request lasts one cycle",
        {draw_player, draw_dealer}, 0);
    player_total = 5'(ptot);
    dealer_total = 5'(dtot);
    card_valid = 1'b1;
    @(negedge clk);
    card_valid = 1'b0;
  endtask

  // Wait for a round to end (state 0 or 11) and count dealer requests on the way.
  task automatic wait_round_end(output int dreqs);
    int n = 0;
    dreqs = 0;
    while (state_code != 4'd0 && state_code != 4'd11 && n < 40) begin
      if (draw_dealer) dreqs++;
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int model_bal(input int bal, input int req, input int pf, input int df);
    int stake = (req < bal) ? req : bal;
    int delta;
    if (pf >= 22)      delta = -stake;
    else if (df >= 22) delta = stake;
    else               delta = (pf == df) ? 0 : ((pf < df) ? -stake : stake);
    return (bal + delta >= 1000) ? 1000 : bal + delta;
  endfunction

  task automatic play_round(input int bet, input int p_deal, input int p_final,
                            input int d_init, input int d_final, input string name);
    int dreqs;
    int dfin = (d_init < 17) ? d_final : d_init;
    @(negedge clk);
    bet_in = 4'(bet);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk(hole_reveal == 1'b0, {"R4 hidden after bet ", name}, hole_reveal, 0);
    serve(1'b0, p_deal, d_init, {"R3 deal card 1 to player ", name});
    serve(1'b1, p_deal, d_init, {"R3 deal card 2 to dealer ", name});
    serve(1'b0, p_deal, d_init, {"R3 deal card 3 to player ", name});
    serve(1'b1, p_deal, d_init, {"R3 deal card 4 to dealer ", name});
    chk(state_code == 4'd3, {"R3 player turn after deal ", name}, state_code, 3);
    chk(hole_reveal == 1'b0, {"R4 hidden in player turn ", name}, hole_reveal, 0);
    if (p_final != p_deal) begin
      hit = 1'b1;
      @(negedge clk);
      hit = 1'b0;
      serve(1'b0, p_final, d_init, {"R5 hit gives player card ", name});
    end
    if (p_final <= 21) begin
      stand = 1'b1;
      @(negedge clk);
      stand = 1'b0;
      chk(hole_reveal == 1'b1 && state_code == 4'd6, {"R4 reveal on stand ", name},
          {hole_reveal, state_code}, 16 + 6);
      if (d_init < 17)
        serve(1'b1, p_final, d_final, {"R6 dealer draws at 16 or less ", name});
    end
    wait_round_end(dreqs);
    if (p_final > 21)
      chk(dreqs == 0, {"R5 no dealer card after bust ", name}, dreqs, 0);
    else
      chk(dreqs == 0, {"R6 dealer stops at 17 or more ", name}, dreqs, 0);
    exp_bal = model_bal(exp_bal, bet, p_final, dfin);
    chk(int'(balance) == exp_bal, {"R7 settled balance ", name}, int'(balance), exp_bal);
    chk(game_over == (exp_bal == 0 || exp_bal == 1000), {"R8 game over flag ", name},
        game_over, (exp_bal == 0 || exp_bal == 1000) ? 1 : 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(int'(balance) == 200, "R1 reset balance", int'(balance), 200);
    chk(state_code == 4'd0, "R1 reset state", state_code, 0);
    chk({draw_player, draw_dealer, hole_reveal, game_over} == 4'b0, "R1 reset outputs",
        {draw_player, draw_dealer, hole_reveal, game_over}, 0);
  endtask

  task automatic t_zero_bet();
    int reqs = 0;
    bet_in = 4'd0;
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    repeat (4) begin
      if (draw_player || draw_dealer) reqs++;
      @(negedge clk);
    end
    chk(state_code == 4'd0, "R2 zero bet stays in betting", state_code, 0);
    chk(reqs == 0, "R2 zero bet requests no card", reqs, 0);
  endtask

  task automatic t_over_inert();
    int reqs = 0;
    int held = int'(balance);
    bet_in = 4'd5;
    advance = 1'b1; hit = 1'b1; stand = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (draw_player || draw_dealer) reqs++;
    end
    advance = 1'b0; hit = 1'b0; stand = 1'b0;
    @(negedge clk);
    chk(state_code == 4'd11 && game_over, "R8 game over is terminal", state_code, 11);
    chk(int'(balance) == held, "R8 balance frozen after game over", int'(balance), held);
    chk(reqs == 0, "R8 no card after game over", reqs, 0);
  endtask

  initial begin
    t_reset();
    t_zero_bet();
    play_round(10, 12, 20, 10, 18, "win after hit");
    play_round(5, 14, 25, 9, 9, "bust");
    play_round(7, 18, 18, 18, 18, "push");
    play_round(9, 15, 15, 12, 24, "dealer bust");
    play_round(4, 17, 17, 19, 19, "lose");
    play_round(6, 20, 20, 16, 17, "dealer draws from 16");
    while (exp_bal >= 15)
      play_round(15, 18, 18, 20, 20, "drain");
    play_round(15, 19, 19, 20, 20, "clamped loss");
    chk(int'(balance) == 0 && game_over, "R9 clamped bet empties balance", int'(balance), 0);
    t_over_inert();
    do_reset();
    chk(int'(balance) == 200, "R1 balance after second reset", int'(balance), 200);
    while (exp_bal < 1000)
      play_round(15, 20, 20, 18, 18, "climb");
    chk(int'(balance) == 1000, "R7 win saturates at ceiling", int'(balance), 1000);
    chk(state_code == 4'd11, "R8 ceiling ends game", state_code, 11);
    finish_run();
  end
endmodule